// File: doc/BRIEF.md
# Converter Readout Sequencer

This block is the host side of a serial converter link in which the converter is an SPI slave that is read only once its conversion has finished. A free-running timer, with a period given in system clocks, issues a convert-start pulse of programmable width. The block then waits for the converter's busy line to fall. It responds to that falling transition, as an edge-triggered interrupt line would, and not to the line being low.

After the falling edge the block drives chip select low and runs an SPI master in mode 1. SCK idles low, and each bit is captured on the falling edge of its clock pulse. The result is read as two bytes, most significant bit first, under one chip-select window. There is a short idle-low gap between the two bytes.

The first byte fills the upper half of the result word and the second byte fills the lower half. A one-cycle valid strobe marks the new word. If a timer tick arrives while a conversion or a read is still in progress, that tick is dropped and reported on an overrun strobe.

Top module: `adc_readout_seq`

## Requirements
- R1: While reset is held and directly after it, cnvst is 0, cs_n is 1, sck is 0, valid is 0, overrun is 0 and result is 0.
- R2: When every conversion and read ends inside the timer period, consecutive rising edges of cnvst are exactly `period` clocks apart. A period of 0 acts as 1.
- R3: Each cnvst pulse is high for exactly `cnv_len` clocks. A cnv_len of 0 gives a pulse 1 clock long.
- R4: A busy line that is held low, or that rises, never starts a read. cs_n stays 1 until busy goes from 1 to 0.
- R5: A 1-to-0 transition of busy seen on two successive clock edges makes cs_n go low on the second of those edges.
- R6: The result equals the 16 bits the slave presents, most significant bit first. The slave changes miso after each rising SCK edge, and the block captures miso on each falling SCK edge.
- R7: SCK is high for h clocks and low for h clocks, where h = sck_div/2 rounded down and h is at least 1. SCK gives exactly 16 rising edges per read. Between the last bit of the first byte and the first bit of the second byte there is one extra low half-period, so those rising edges are 3h clocks apart.
- R8: The first byte received goes to result[15:8] and the second to result[7:0]. valid is high for exactly one clock after the last falling SCK edge.
- R9: A timer tick that arrives while a conversion or read is in progress raises overrun for one clock and starts no new cnvst pulse. cnvst is never high while cs_n is low.
- R10: cs_n stays low for the whole 16-bit read. SCK stays low whenever cs_n is high, and cs_n is back at 1 when valid is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period | input | PER_W | Timer period in clocks between conversion starts |
| cnv_len | input | LEN_W | Convert-start pulse width in clocks |
| sck_div | input | DIV_W | System clocks per SCK period (minimum 2) |
| busy | input | 1 | Converter busy line |
| miso | input | 1 | Serial data from the converter |
| cnvst | output | 1 | Convert-start pulse |
| cs_n | output | 1 | Active-low chip select |
| sck | output | 1 | Serial clock, idles low |
| result | output | BYTE_W*NBYTES | Assembled conversion result |
| valid | output | 1 | One-cycle strobe for a new result |
| overrun | output | 1 | One-cycle strobe for a dropped timer tick |

## Verification
Reads are run with the SCK divider at 2, at an odd value (7) and at 1. The divider at 1 must clamp to the same timing as 2, and the odd value shows whether the half-period rounds down. The data words 0xA55A, 0x8001, 0x7FFE and 0xC3F0 differ from each other at the byte boundary and in the end bits. A word with both halves swapped, or shifted by one bit, therefore gives a wrong value, and so does a bit captured on the wrong SCK edge. The busy line is tried three ways: held low for a long time, then raised, then dropped. This separates edge detection from level detection. A timer period shorter than one read makes ticks arrive during a transfer, so the overrun path is exercised while a read is still running.

// File: rtl/adc_readout_seq.sv
module adc_readout_seq #(
  parameter int PER_W  = 16,
  parameter int LEN_W  = 8,
  parameter int DIV_W  = 8,
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PER_W-1:0]         period,
  input  logic [LEN_W-1:0]         cnv_len,
  input  logic [DIV_W-1:0]         sck_div,
  input  logic                     busy,
  input  logic                     miso,
  output logic                     cnvst,
  output logic                     cs_n,
  output logic                     sck,
  output logic [BYTE_W*NBYTES-1:0] result,
  output logic                     valid,
  output logic                     overrun
);
  localparam int NBITS = BYTE_W * NBYTES;
  localparam int BC_W  = $clog2(BYTE_W);
  localparam int NB_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(BYTE_W - 1);
  localparam logic [NB_W-1:0] NB_LAST = NB_W'(NBYTES - 1);

  typedef enum logic [1:0] {S_IDLE, S_CONV, S_WAIT, S_XFER} st_t;

  st_t              st;
  logic [PER_W-1:0] tmr;
  logic [LEN_W-1:0] lc;
  logic [DIV_W-2:0] hc;
  logic [BC_W-1:0]  bc;
  logic [NB_W-1:0]  bidx;
  logic [NBITS-1:0] sh;
  logic             gap, busy_q;

  logic [PER_W-1:0] per_m1;
  logic [LEN_W-1:0] len_m1;
  logic [DIV_W-2:0] half_m1;
  logic             tick;

  assign per_m1  = (period == '0) ? '0 : period - 1'b1;
  assign len_m1  = (cnv_len == '0) ? '0 : cnv_len - 1'b1;
  assign half_m1 = (sck_div < DIV_W'(4)) ? '0 : sck_div[DIV_W-1:1] - 1'b1;
  assign tick    = (tmr >= per_m1);

  assign cnvst = (st == S_CONV);
  assign cs_n  = (st != S_XFER);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      tmr     <= '0;
      lc      <= '0;
      hc      <= '0;
      bc      <= '0;
      bidx    <= '0;
      sh      <= '0;
      gap     <= 1'b0;
      sck     <= 1'b0;
      busy_q  <= 1'b0;
      result  <= '0;
      valid   <= 1'b0;
      overrun <= 1'b0;
    end else begin
      busy_q  <= busy;
      valid   <= 1'b0;
      overrun <= tick && (st != S_IDLE);
      tmr     <= tick ? '0 : tmr + 1'b1;
      case (st)
        S_IDLE: if (tick) begin
          st <= S_CONV;
          lc <= '0;
        end
        S_CONV: begin
          if (lc == len_m1) st <= S_WAIT;
          else              lc <= lc + 1'b1;
        end
        S_WAIT: if (busy_q && !busy) begin
          st   <= S_XFER;
          hc   <= '0;
          gap  <= 1'b1;
          sck  <= 1'b0;
          bc   <= '0;
          bidx <= '0;
        end
        S_XFER: begin
          if (hc != half_m1) begin
            hc <= hc + 1'b1;
          end else begin
            hc <= '0;
            if (gap) begin
              gap <= 1'b0;
            end else if (!sck) begin
              sck <= 1'b1;
            end else begin
              sck <= 1'b0;
              sh  <= {sh[NBITS-2:0], miso};
              if (bc == BC_LAST) begin
                bc <= '0;
                if (bidx == NB_LAST) begin
                  st     <= S_IDLE;
                  result <= {sh[NBITS-2:0], miso};
                  valid  <= 1'b1;
                end else begin
                  bidx <= bidx + 1'b1;
                  gap  <= 1'b1;
                end
              end else begin
                bc <= bc + 1'b1;
              end
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/adc_readout_chk.sv
module adc_readout_chk (
  input logic clk,
  input logic rst_n,
  input logic cnvst,
  input logic cs_n,
  input logic sck,
  input logic busy,
  input logic valid
);
  // R10
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  // R9
  no_cnv_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnvst && !cs_n));

  // R8
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  // R10
  valid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (cs_n && !$past(cs_n)));

  // R5
  read_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> ($past(busy, 2) && !$past(busy)));
endmodule

bind adc_readout_seq adc_readout_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cnvst(cnvst), .cs_n(cs_n),
  .sck(sck), .busy(busy), .valid(valid)
);

// File: tb/sim_adc_readout_seq.sv
module sim_adc_readout_seq;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] period = 16'd300;
  logic [7:0]  cnv_len = 8'd3;
  logic [7:0]  sck_div = 8'd2;
  logic        busy = 1'b0;
  logic        miso = 1'b0;
  logic        cnvst, cs_n, sck, valid, overrun;
  logic [15:0] result;

  int checks = 0;
  int fails = 0;

  always #(CLK_P/2) clk = ~clk;

  adc_readout_seq u0 (
    .clk(clk), .rst_n(rst_n), .period(period), .cnv_len(cnv_len),
    .sck_div(sck_div), .busy(busy), .miso(miso), .cnvst(cnvst),
    .cs_n(cs_n), .sck(sck), .result(result), .valid(valid), .overrun(overrun)
  );

  logic [15:0] sword = 16'h0000;
  int sidx = 0;
  always @(posedge sck or posedge cs_n) begin
    if (cs_n) sidx <= 0;
    else begin
      miso <= sword[15 - sidx];
      sidx <= sidx + 1;
    end
  end

  bit auto_busy = 1'b1;
  int busy_t = 10;
  always begin
    @(negedge cnvst);
    if (auto_busy) begin
      @(negedge clk) busy = 1'b1;
      repeat (busy_t) @(negedge clk);
      busy = 1'b0;
    end
  end

  int cyc = 0, cnv_rise_t = 0, cnv_int = 0, cnv_hi = 0, cnv_w = 0;
  int rise_n = 0, frame_rises = 0, ovr_cnt = 0, cnv_in_read = 0;
  int rise_t [16];
  logic cnv_prev = 1'b0, cs_prev = 1'b1, sck_prev = 1'b0;
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (cnvst && !cnv_prev) begin
        cnv_int = cyc - cnv_rise_t;
        cnv_rise_t = cyc;
        cnv_hi = 0;
      end
      if (cnvst) cnv_hi = cnv_hi + 1;
      if (!cnvst && cnv_prev) cnv_w = cnv_hi;
      if (!cs_n && cs_prev) rise_n = 0;
      if (sck && !sck_prev) begin
        if (rise_n < 16) rise_t[rise_n] = cyc;
        rise_n = rise_n + 1;
      end
      if (cs_n && !cs_prev) frame_rises = rise_n;
      if (overrun) ovr_cnt = ovr_cnt + 1;
      if (cnvst && !cs_n) cnv_in_read = cnv_in_read + 1;
      cnv_prev = cnvst;
      cs_prev = cs_n;
      sck_prev = sck;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (valid) return;
    end
    chk(1'b0, "wait_valid timeout", 0, 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(cnvst == 0 && cs_n == 1 && sck == 0, "R1 ports in reset", {cnvst, cs_n, sck}, 3'b010);
    chk(valid == 0 && overrun == 0 && result == 0, "R1 result in reset", result, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cnvst == 0 && cs_n == 1 && sck == 0 && valid == 0, "R1 after reset",
        {cnvst, cs_n, sck, valid}, 4'b0100);
  endtask

  task automatic t_frame(input int per, input int len, input int div, input logic [15:0] w);
    int h, exp_w;
    h = (div >> 1) < 1 ? 1 : (div >> 1);
    exp_w = len < 1 ? 1 : len;
    period = 16'(per);
    cnv_len = 8'(len);
    sck_div = 8'(div);
    sword = w;
    wait_valid();
    wait_valid();
    chk(result == w, "R6 result value", result, w);
    chk(result[15:8] == w[15:8] && result[7:0] == w[7:0], "R8 byte order", result, w);
    chk(cs_n == 1, "R10 cs released at valid", cs_n, 1);
    @(negedge clk);
    chk(valid == 0, "R8 valid one cycle", valid, 0);
    chk(frame_rises == 16, "R7 sck rises per read", frame_rises, 16);
    chk(rise_t[1] - rise_t[0] == 2 * h, "R7 sck period", rise_t[1] - rise_t[0], 2 * h);
    chk(rise_t[8] - rise_t[7] == 3 * h, "R7 byte gap", rise_t[8] - rise_t[7], 3 * h);
    chk(cnv_w == exp_w, "R3 cnvst width", cnv_w, exp_w);
    chk(cnv_int == per, "R2 cnvst spacing", cnv_int, per);
  endtask

  task automatic t_level_busy();
    int low_seen;
    auto_busy = 1'b0;
    busy = 1'b0;
    period = 16'd2000;
    sword = 16'h7FFE;
    @(negedge cnvst);
    low_seen = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!cs_n) low_seen++;
    end
    chk(low_seen == 0, "R4 low busy level ignored", low_seen, 0);
    busy = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs_n == 1, "R4 busy rise ignored", cs_n, 1);
    busy = 1'b0;
    @(negedge clk);
    chk(cs_n == 0, "R5 read starts on busy fall", cs_n, 0);
    wait_valid();
    chk(result == 16'h7FFE, "R6 result after edge start", result, 16'h7FFE);
    auto_busy = 1'b1;
  endtask

  task automatic t_overrun();
    int o0;
    o0 = ovr_cnt;
    period = 16'd40;
    sck_div = 8'd8;
    sword = 16'hC3F0;
    wait_valid();
    wait_valid();
    chk(ovr_cnt > o0, "R9 overrun raised", ovr_cnt - o0, 1);
    chk(cnv_in_read == 0, "R9 no cnvst during read", cnv_in_read, 0);
    chk(result == 16'hC3F0, "R9 result intact", result, 16'hC3F0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_frame(300, 3, 2, 16'hA55A);
    t_frame(400, 0, 7, 16'h8001);
    t_frame(250, 5, 1, 16'hC3F0);
    t_level_busy();
    t_overrun();
    t_frame(320, 2, 4, 16'h0FF1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule